// File: doc/BRIEF.md
# Triple-Channel Countdown Watchdog

This peripheral holds three independent 16-bit countdown watchdogs behind a small register bus that accepts byte and halfword accesses. A prescaler divides the system clock into a tick every tenth of a second. Each running channel moves one count lower on every tick. Software starts a channel by writing its limit register. Software keeps the channel alive by reading the channel's counter register. That read returns the present count and, as a side effect, reloads the counter from the limit.

The three channels do different things when they expire. Channel 0 raises a level interrupt. Channel 1 drives a pulse on a CPU-only reset output. Channel 2 drives a pulse on a board-wide reset output. A shared mask byte can suppress the action of any channel. A masked channel still counts down and still sets its expired flag, but its output stays quiet.

Halfword registers appear on the bus with their two bytes exchanged. Byte registers use bus bits 7:0.

Top module: `tri_wdog`

## Requirements
- R1: After reset, every channel's counter and limit hold 1, no channel is running or expired, the mask byte is 0, and irq_o, cpu_rst_o and sys_rst_o are low.
- R2: The prescaler emits one tick every CLK_HZ/10 clock cycles. A running channel's counter decreases by one on each tick.
- R3: A halfword write to a channel's limit register (offset 0x4 in that channel's window) loads both the limit and the counter with the written value, sets running and clears expired.
- R4: A read of a channel's counter register (offset 0x0) returns the count from before the read. If the channel is running, the counter reloads from the limit on that edge. This reload takes priority over a tick in the same cycle.
- R5: A counter read on a channel that is not running leaves the counter unchanged. A read of the limit register never changes any state.
- R6: A running channel that receives a tick while its count is 1 or 0 expires: the counter becomes 0 and holds there, running clears and expired sets. Expired stays set until the next limit write.
- R7: The status byte is at offset 0x8 of each window. Bit 0 is running and bit 1 is expired. Bits 15:2 read as 0.
- R8: A halfword value v is presented on the bus as {v[7:0], v[15:8]}, both for writes and for reads.
- R9: The mask byte is at 0x30. Bit n masks channel n, and bits 15:3 read as 0. A masked channel keeps counting and can still expire.
- R10: irq_o is high exactly while channel 0 is expired and mask bit 0 is clear.
- R11: On the cycle that channel 1 expires with mask bit 1 clear, cpu_rst_o goes high for RST_PULSE_CYC cycles. Channel 2 does the same on sys_rst_o using mask bit 2. An expiry while masked produces no pulse.
- R12: Channel windows start at 0x00, 0x10 and 0x20. Every other address, including the auxiliary byte at 0x34, reads as 0. Writes to status, counter or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 16 | Write data (halfword values byte-swapped) |
| rdata_o | output | 16 | Read data, valid while a read is requested |
| irq_o | output | 1 | Channel 0 expiry interrupt (level) |
| cpu_rst_o | output | 1 | Channel 1 CPU reset pulse |
| sys_rst_o | output | 1 | Channel 2 board reset pulse |

## Verification
The bench builds the block with CLK_HZ=40 and RST_PULSE_CYC=5. With these values a tick comes every four cycles and a reset pulse lasts five cycles. Expiry, kick timing against the prescaler phase, and the exact pulse length therefore all fall within a few dozen cycles. The same settings let the bench set up a collision between a counter read and a tick, and they let it count every cycle of a pulse window while a masked channel expires silently next to an unmasked one.

// File: rtl/tri_wdog_pkg.sv
package tri_wdog_pkg;
  localparam int unsigned NUM_CH = 3;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 6;

  localparam logic [1:0] WIN_CTRL = 2'd3;
  localparam logic [3:0] OFS_CNT  = 4'h0;
  localparam logic [3:0] OFS_LIM  = 4'h4;
  localparam logic [3:0] OFS_STAT = 4'h8;
  localparam logic [3:0] OFS_MASK = 4'h0;
  localparam logic [3:0] OFS_AUX  = 4'h4;

  // bus carries halfwords low byte first
  function automatic logic [15:0] swap16(logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction
endpackage

// File: rtl/tri_wdog_presc.sv
module tri_wdog_presc #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] cnt_q;

  assign tick_o = (cnt_q == W'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tri_wdog_chan.sv
module tri_wdog_chan #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lim_we_i,
  input  logic [CNT_W-1:0] lim_val_i,
  input  logic             cnt_rd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o,
  output logic             run_o,
  output logic             exp_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, lim_q;
  logic run_q, exp_q, kick;

  assign kick     = cnt_rd_i && run_q;
  assign expire_o = tick_i && run_q && !lim_we_i && !kick && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(1);
      lim_q <= CNT_W'(1);
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (lim_we_i) begin
      lim_q <= lim_val_i;
      cnt_q <= lim_val_i;
      run_q <= 1'b1;
      exp_q <= 1'b0;
    end else if (kick) begin
      cnt_q <= lim_q;
    end else if (expire_o) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b1;
    end else if (tick_i && run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
  assign run_o = run_q;
  assign exp_o = exp_q;
endmodule

// File: rtl/tri_wdog_pulse.sv
module tri_wdog_pulse #(
  parameter int unsigned LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int unsigned W = $clog2(LEN + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (trig_i)        cnt_q <= W'(LEN);
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/tri_wdog.sv
module tri_wdog
  import tri_wdog_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 50_000_000,
  parameter int unsigned RST_PULSE_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  localparam int unsigned TICK_DIV = (CLK_HZ / 10 > 0) ? CLK_HZ / 10 : 1;

  logic [1:0] win;
  logic [3:0] ofs;
  logic       tick;
  logic [NUM_CH-1:0] lim_we, cnt_rd, run_v, exp_v, expire_v, mask_q;
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CNT_W-1:0]  lim_v [NUM_CH];
  logic [2:1]        rst_pls;
  logic              unused_evt0;

  assign win = addr_i[5:4];
  assign ofs = addr_i[3:0];

  tri_wdog_presc #(.DIV(TICK_DIV)) u_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign lim_we[g] = req_i &&  we_i && (win == 2'(g)) && (ofs == OFS_LIM);
    assign cnt_rd[g] = req_i && !we_i && (win == 2'(g)) && (ofs == OFS_CNT);

    tri_wdog_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick),
      .lim_we_i (lim_we[g]),
      .lim_val_i(swap16(wdata_i)),
      .cnt_rd_i (cnt_rd[g]),
      .cnt_o    (cnt_v[g]),
      .lim_o    (lim_v[g]),
      .run_o    (run_v[g]),
      .exp_o    (exp_v[g]),
      .expire_o (expire_v[g])
    );
  end

  for (genvar g = 1; g < NUM_CH; g++) begin : g_rst
    tri_wdog_pulse #(.LEN(RST_PULSE_CYC)) u_pulse (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .trig_i (expire_v[g] && !mask_q[g]),
      .pulse_o(rst_pls[g])
    );
  end

  assign unused_evt0 = expire_v[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (req_i && we_i && win == WIN_CTRL && ofs == OFS_MASK)
      mask_q <= wdata_i[NUM_CH-1:0];
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (win == 2'(i)) begin
          unique case (ofs)
            OFS_CNT:  rdata_o = swap16(cnt_v[i]);
            OFS_LIM:  rdata_o = swap16(lim_v[i]);
            OFS_STAT: rdata_o = {14'b0, exp_v[i], run_v[i]};
            default:  rdata_o = '0;
          endcase
        end
      end
      if (win == WIN_CTRL && ofs == OFS_MASK)
        rdata_o = {{(16-NUM_CH){1'b0}}, mask_q};
    end
  end

  assign irq_o     = exp_v[0] && !mask_q[0];
  assign cpu_rst_o = rst_pls[1];
  assign sys_rst_o = rst_pls[2];
endmodule

// File: rtl/tri_wdog_chk.sv
module tri_wdog_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [5:0]  addr_i,
  input logic        irq_o,
  input logic        cpu_rst_o,
  input logic        sys_rst_o,
  input logic [2:0]  run_i,
  input logic [2:0]  exp_i,
  input logic [15:0] cnt0_i
);
  logic lim0_wr, mask_wr, cnt0_rd;
  assign lim0_wr = req_i && we_i && addr_i == 6'h04;
  assign mask_wr = req_i && we_i && addr_i == 6'h30;
  assign cnt0_rd = req_i && !we_i && addr_i == 6'h00;

  assert_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lim0_wr |=> run_i[0] && !exp_i[0]);

  assert_run_exp_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(run_i & exp_i)));

  assert_hold_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exp_i[0] && !lim0_wr) |=> exp_i[0] && cnt0_i == 16'h0);

  assert_idle_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt0_rd && !run_i[0]) |=> $stable(cnt0_i));

  assert_irq_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !mask_wr && !lim0_wr) |=> irq_o);

  assert_irq_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> exp_i[0]);

  assert_cpu_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_o) |-> $past(run_i[1]));

  assert_sys_src_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> $past(run_i[2]));
endmodule

bind tri_wdog tri_wdog_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .irq_o    (irq_o),
  .cpu_rst_o(cpu_rst_o),
  .sys_rst_o(sys_rst_o),
  .run_i    (run_v),
  .exp_i    (exp_v),
  .cnt0_i   (cnt_v[0])
);

// File: tb/tb_tri_wdog.sv
module tb_tri_wdog;
  localparam int CLK_HZ = 40;
  localparam int DIV    = CLK_HZ / 10;
  localparam int PULSE  = 5;

  logic        clk = 0, rst_n = 0;
  logic        req = 0, we = 0;
  logic [5:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata;
  logic        irq, cpu_rst, sys_rst;

  int errors = 0, checks = 0;

  tri_wdog #(.CLK_HZ(CLK_HZ), .RST_PULSE_CYC(PULSE)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu_rst),
    .sys_rst_o(sys_rst)
  );

  always #4 clk = ~clk;

  function automatic logic [15:0] sw(logic [15:0] v);
    return {v[7:0], v[15:8]};
  endfunction

  // behavioural reference
  int m_cnt[3], m_lim[3], m_pls[3], m_pre;
  bit m_run[3], m_exp[3], m_tk, m_lw, m_rd, m_evt;
  bit [2:0] m_mask;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 1; m_lim[i] = 1; m_run[i] = 0; m_exp[i] = 0; m_pls[i] = 0;
      end
      m_pre = 0; m_mask = 0;
    end else begin
      m_tk  = (m_pre == DIV - 1);
      m_pre = m_tk ? 0 : m_pre + 1;
      for (int c = 0; c < 3; c++) begin
        m_lw  = req && we  && addr == 6'(c * 16 + 4);
        m_rd  = req && !we && addr == 6'(c * 16);
        m_evt = 0;
        if (m_lw) begin
          m_lim[c] = sw(wdata); m_cnt[c] = m_lim[c]; m_run[c] = 1; m_exp[c] = 0;
        end else if (m_rd && m_run[c]) begin
          m_cnt[c] = m_lim[c];
        end else if (m_tk && m_run[c]) begin
          if (m_cnt[c] <= 1) begin
            m_cnt[c] = 0; m_run[c] = 0; m_exp[c] = 1; m_evt = 1;
          end else m_cnt[c] = m_cnt[c] - 1;
        end
        if (m_evt && !m_mask[c]) m_pls[c] = PULSE;
        else if (m_pls[c] > 0)   m_pls[c] = m_pls[c] - 1;
      end
      if (req && we && addr == 6'h30) m_mask = wdata[2:0];
    end
  end

  function automatic logic [15:0] m_rdata(logic [5:0] a);
    int c;
    c = a[5:4];
    if (c < 3) begin
      case (a[3:0])
        4'h0: return sw(16'(m_cnt[c]));
        4'h4: return sw(16'(m_lim[c]));
        4'h8: return {14'b0, m_exp[c], m_run[c]};
        default: return 16'h0;
      endcase
    end
    if (a[3:0] == 4'h0) return {13'b0, m_mask};
    return 16'h0;
  endfunction

  task automatic chk(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      chk(irq == (m_exp[0] && !m_mask[0]), "R10 irq_o", 16'(irq), 16'(m_exp[0] && !m_mask[0]));
      chk(cpu_rst == (m_pls[1] > 0), "R11 cpu_rst_o", 16'(cpu_rst), 16'(m_pls[1] > 0));
      chk(sys_rst == (m_pls[2] > 0), "R11 sys_rst_o", 16'(sys_rst), 16'(m_pls[2] > 0));
      if (req && !we) chk(rdata == m_rdata(addr), "R2/R4 model rdata", rdata, m_rdata(addr));
    end
  end

  task automatic wr(logic [5:0] a, logic [15:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [15:0] exp, string tag);
    @(negedge clk); req = 1; we = 0; addr = a;
    #2 chk(rdata === exp, tag, rdata, exp);
    @(negedge clk); req = 0;
  endtask

  task automatic rd_m(logic [5:0] a);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(int n, bit sel_sys, output int hits);
    hits = 0;
    repeat (n) begin
      @(negedge clk); #2;
      if (sel_sys ? sys_rst : cpu_rst) hits++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int h;
    idle(3);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #2 chk({irq, cpu_rst, sys_rst} == 3'b000, "R1 outputs", 16'({irq, cpu_rst, sys_rst}), 16'h0);
    for (int c = 0; c < 3; c++) begin
      rd(6'(c * 16),     16'h0100, "R1 counter");
      rd(6'(c * 16 + 4), 16'h0100, "R1 limit");
      rd(6'(c * 16 + 8), 16'h0000, "R1 status");
    end
    rd(6'h30, 16'h0000, "R1 mask");
    // R12 decode
    rd(6'h0C, 16'h0000, "R12 unmapped 0x0C");
    rd(6'h3C, 16'h0000, "R12 unmapped 0x3C");
    rd(6'h34, 16'h0000, "R12 aux byte");
    wr(6'h08, 16'hFFFF);
    rd(6'h08, 16'h0000, "R12 status write ignored");
    wr(6'h00, 16'h0500);
    wr(6'h0C, 16'h0500);
    rd(6'h00, 16'h0100, "R12 counter write ignored");
    // R8 / R3 / R7
    wr(6'h04, 16'h3412);
    rd(6'h04, 16'h3412, "R8 limit swapped");
    rd(6'h08, 16'h0001, "R3 R7 status running");
    rd(6'h04, 16'h3412, "R5 limit read no effect");
    rd_m(6'h00);
    // R2 / R6 expiry and R10 irq
    wr(6'h04, 16'h0300);
    idle(20);
    rd(6'h08, 16'h0002, "R6 R7 status expired");
    rd(6'h00, 16'h0000, "R6 counter holds zero");
    chk(irq == 1'b1, "R10 irq on expiry", 16'(irq), 16'h1);
    // R5 idle counter read
    rd(6'h00, 16'h0000, "R5 read of stopped counter");
    wr(6'h30, 16'h0001);
    #2 chk(irq == 1'b0, "R10 irq masked", 16'(irq), 16'h0);
    wr(6'h30, 16'h0000);
    #2 chk(irq == 1'b1, "R10 irq unmasked again", 16'(irq), 16'h1);
    // R4 kicks keep channel 0 alive
    wr(6'h04, 16'h0500);
    #2 chk(irq == 1'b0, "R3 limit write clears expired", 16'(irq), 16'h0);
    for (int k = 0; k < 30; k++) rd_m(6'h00);
    rd(6'h08, 16'h0001, "R4 kicked channel still running");
    idle(30);
    rd(6'h08, 16'h0002, "R6 expires without kicks");
    // R11 CPU reset pulse
    wr(6'h14, 16'h0200);
    count_high(25, 1'b0, h);
    chk(h == PULSE, "R11 cpu_rst_o length", 16'(h), 16'(PULSE));
    // R11 board reset pulse
    wr(6'h24, 16'h0200);
    count_high(25, 1'b1, h);
    chk(h == PULSE, "R11 sys_rst_o length", 16'(h), 16'(PULSE));
    // R9 masked channel counts but stays silent
    wr(6'h30, 16'hFFFF);
    rd(6'h30, 16'h0007, "R9 mask readback");
    wr(6'h24, 16'h0200);
    count_high(25, 1'b1, h);
    chk(h == 0, "R9 R11 masked no pulse", 16'(h), 16'h0);
    rd(6'h28, 16'h0002, "R9 masked channel expired");
    // R2 count rate via model
    wr(6'h30, 16'h0000);
    wr(6'h14, 16'h0A00);
    idle(9);
    rd_m(6'h10);
    idle(50);
    rd(6'h18, 16'h0002, "R2 channel 1 expired after 10 ticks");
    idle(10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule